// File: doc/BRIEF.md
# SMRAM and Flash Access Gate

This chipset-side block sits in the memory path and picks a target for every transaction. Each request carries an address, a write flag and an attribute that says whether the requester is executing in system management mode (SMM). The block routes the request to DRAM, to the video-memory window, to a zero-returning sink, or to the memory-mapped NOR flash. It also marks as dropped any write that must not take effect. Two protected areas exist. One is the fixed 128 KB legacy window. The other is a top segment placed directly below the top of low DRAM. Neither is visible to requesters outside SMM. Flash can only be written from SMM.

A small configuration register holds four fields: a global enable, an open override for the legacy window, a protected-segment size code, and a lock. Once the lock is set, the register is frozen until reset. A separate I/O decoder watches for writes to the management trigger port and produces a one-cycle SMI request.

Every routing decision is combinational from the request, the attribute and the current configuration. The outcome is registered, so it appears on the response outputs exactly one clock later.

Top module: `smram_gate`

## Requirements
- R1: After reset, `cfg_q` reads 5'b01100, which means enable=0, open=0, size code 11 (no segment) and lock=0. `rsp_valid` and `smi_pulse` are both low.
- R2: A request to 0xA0000..0xBFFFF goes to video memory (target 1) in two cases: enable is 0, or the request is non-SMM while open is 0.
- R3: With enable=1, a request to 0xA0000..0xBFFFF goes to DRAM (target 0) when it carries the SMM attribute or when open is 1.
- R4: The segment size code lives in `cfg_q[3:2]`. Code 00 means 1 MB, 01 means 2 MB, 10 means 8 MB and 11 means no segment. The segment spans from `top_low_mem` minus the size up to, but not including, `top_low_mem`. SMM requests inside it go to DRAM (target 0).
- R5: A non-SMM request inside the segment goes to the zero sink (target 2). If it is a write, `rsp_drop` is 1.
- R6: An address at or above FLASH_BASE goes to flash (target 3). A flash write without the SMM attribute has `rsp_drop`=1. A flash write with the SMM attribute has `rsp_drop`=0.
- R7: A configuration write sets enable from bit 0, open from bit 1, size from bits 3:2 and lock from bit 4. While lock is 1, configuration writes are ignored until reset.
- R8: Open reads 0 whenever lock is 1, including after a write that sets both bits together.
- R9: An I/O write to port 0x00B2 raises `smi_pulse` for exactly one cycle, in the next cycle. I/O reads and writes to other ports do not raise it.
- R10: `rsp_valid`, `rsp_target` and `rsp_drop` describe the request presented one clock earlier. `rsp_valid` follows `req_valid` with a one-cycle delay.
- R11: Any other address below `top_low_mem` goes to DRAM. Any address from `top_low_mem` up to FLASH_BASE goes to the zero sink, and writes there are dropped. Reads never set `rsp_drop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | {lock, size[1:0], open, enable} |
| cfg_q | output | 5 | Current configuration, same layout |
| top_low_mem | input | AW | Top of low usable DRAM (exclusive) |
| req_valid | input | 1 | Memory request present |
| req_write | input | 1 | Request is a write |
| req_smm | input | 1 | Requester is in SMM |
| req_addr | input | AW | Request address |
| rsp_valid | output | 1 | Registered response valid |
| rsp_target | output | 2 | 0 DRAM, 1 video, 2 zero sink, 3 flash |
| rsp_drop | output | 1 | The write is discarded |
| io_valid | input | 1 | I/O cycle present |
| io_write | input | 1 | I/O cycle is a write |
| io_port | input | PW | I/O port number |
| smi_pulse | output | 1 | One-cycle SMI request |

## Verification
A corrupted configuration bit shows up on `cfg_q` in the next cycle. It also changes the target of the next request that touches the legacy window or the segment. A lock that clears early appears as soon as a later configuration write goes through. A wrong segment bound shows up only at addresses right at the base or the top, so the bench probes those edges for every size code. A decode error surfaces on `rsp_target` or `rsp_drop` exactly one cycle after the offending request, because a reference model is compared with the outputs on every clock.

// File: rtl/smg_pkg.sv
package smg_pkg;
  typedef enum logic [1:0] {
    TGT_DRAM  = 2'd0,
    TGT_VIDEO = 2'd1,
    TGT_ZERO  = 2'd2,
    TGT_FLASH = 2'd3
  } tgt_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] tsz;
    logic       open;
    logic       en;
  } cfg_t;

  localparam int         CFG_W   = 5;
  localparam logic [1:0] TSZ_OFF = 2'b11;

  // Byte length of the protected top segment for a size code.
  function automatic logic [31:0] seg_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 32'h0010_0000;
      2'b01:   return 32'h0020_0000;
      2'b10:   return 32'h0080_0000;
      default: return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/smg_cfg.sv
module smg_cfg
  import smg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg
);
  cfg_t wr_img;
  cfg_t nxt;

  always_comb begin
    wr_img = cfg_t'(wdata);
    if (wr_img.lock) wr_img.open = 1'b0;
    nxt = (we && !cfg.lock) ? wr_img : cfg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '{lock: 1'b0, tsz: TSZ_OFF, open: 1'b0, en: 1'b0};
    end else begin
      cfg <= nxt;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg.lock |=> cfg.lock); // R7
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (cfg.lock && we) |=> $stable(cfg)); // R7
  AST_OPEN_SHUT: assert property (@(posedge clk) disable iff (rst)
    cfg.lock |-> !cfg.open); // R8
endmodule

// File: rtl/smg_decode.sv
module smg_decode
  import smg_pkg::*;
#(
  parameter int             AW         = 32,
  parameter logic [AW-1:0]  FLASH_BASE = AW'('hFF80_0000)
) (
  input  logic [AW-1:0] addr,
  input  logic          smm,
  input  logic          write,
  input  cfg_t          cfg,
  input  logic [AW-1:0] tolud,
  output tgt_e          tgt,
  output logic          drop
);
  localparam logic [AW-1:0] LEG_LO = AW'('h000A_0000);
  localparam logic [AW-1:0] LEG_HI = AW'('h000C_0000);

  logic [AW-1:0] seg_len;
  logic [AW-1:0] seg_base;
  logic          in_flash, in_leg, in_seg, below_top;

  always_comb begin
    seg_len   = AW'(seg_bytes(cfg.tsz));
    seg_base  = tolud - seg_len;
    in_flash  = addr >= FLASH_BASE;
    in_leg    = (addr >= LEG_LO) && (addr < LEG_HI);
    below_top = addr < tolud;
    in_seg    = (seg_len != '0) && (addr >= seg_base) && below_top;

    tgt  = TGT_ZERO;
    drop = 1'b0;
    if (in_flash) begin
      tgt  = TGT_FLASH;
      drop = write && !smm;
    end else if (in_leg) begin
      tgt = (cfg.en && (smm || cfg.open)) ? TGT_DRAM : TGT_VIDEO;
    end else if (in_seg) begin
      tgt  = smm ? TGT_DRAM : TGT_ZERO;
      drop = write && !smm;
    end else if (below_top) begin
      tgt = TGT_DRAM;
    end else begin
      tgt  = TGT_ZERO;
      drop = write;
    end
  end
endmodule

// File: rtl/smg_smi.sv
module smg_smi #(
  parameter int            PW        = 16,
  parameter logic [PW-1:0] TRIG_PORT = PW'('h00B2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_valid,
  input  logic          io_write,
  input  logic [PW-1:0] io_port,
  output logic          smi_pulse
);
  logic hit;
  assign hit = io_valid && io_write && (io_port == TRIG_PORT);

  always_ff @(posedge clk) begin
    if (rst) smi_pulse <= 1'b0;
    else     smi_pulse <= hit;
  end

  AST_SMI_RAISE: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_write && io_port == TRIG_PORT) |=> smi_pulse); // R9
  AST_SMI_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(io_valid && io_write) |=> !smi_pulse); // R9
endmodule

// File: rtl/smram_gate.sv
module smram_gate
  import smg_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            PW         = 16,
  parameter logic [AW-1:0] FLASH_BASE = AW'('hFF80_0000),
  parameter logic [PW-1:0] TRIG_PORT  = PW'('h00B2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  input  logic [AW-1:0]    top_low_mem,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_smm,
  input  logic [AW-1:0]    req_addr,
  output logic             rsp_valid,
  output logic [1:0]       rsp_target,
  output logic             rsp_drop,
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [PW-1:0]    io_port,
  output logic             smi_pulse
);
  cfg_t cfg;
  tgt_e dec_tgt;
  logic dec_drop;
  tgt_e tgt_q;

  smg_cfg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  smg_decode #(.AW(AW), .FLASH_BASE(FLASH_BASE)) u_dec (
    .addr  (req_addr),
    .smm   (req_smm),
    .write (req_write),
    .cfg   (cfg),
    .tolud (top_low_mem),
    .tgt   (dec_tgt),
    .drop  (dec_drop)
  );

  smg_smi #(.PW(PW), .TRIG_PORT(TRIG_PORT)) u_smi (
    .clk       (clk),
    .rst       (rst),
    .io_valid  (io_valid),
    .io_write  (io_write),
    .io_port   (io_port),
    .smi_pulse (smi_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      tgt_q     <= TGT_DRAM;
      rsp_drop  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      tgt_q     <= dec_tgt;
      rsp_drop  <= req_valid && dec_drop;
    end
  end

  assign rsp_target = tgt_q;
  assign cfg_q      = cfg;

  AST_RSP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R10
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R10
  AST_FLASH_GUARD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_smm && req_addr >= FLASH_BASE) |=> rsp_drop); // R6
  AST_FLASH_PASS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_smm && req_addr >= FLASH_BASE) |=> !rsp_drop); // R6
  AST_ZERO_DROP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_target != 2'(TGT_ZERO) || rsp_drop)); // R5
  AST_READ_KEEP: assert property (@(posedge clk) disable iff (rst)
    !req_write |=> !rsp_drop); // R11
endmodule

// File: tb/smram_gate_test.sv
module smram_gate_test;
  localparam longint unsigned TOLUD = 64'h8000_0000;
  localparam longint unsigned FLASH = 64'hFF80_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic [4:0]  cfg_q;
  logic [31:0] top_low_mem = TOLUD[31:0];
  logic        req_valid = 1'b0, req_write = 1'b0, req_smm = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_drop, smi_pulse;
  logic [1:0]  rsp_target;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_port = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  // reference model state
  int    m_en, m_open, m_tsz, m_lock;
  int    e_valid, e_tgt, e_drop, e_smi;
  string e_tag;

  smram_gate uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .top_low_mem(top_low_mem), .req_valid(req_valid), .req_write(req_write),
    .req_smm(req_smm), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_target(rsp_target), .rsp_drop(rsp_drop), .io_valid(io_valid),
    .io_write(io_write), .io_port(io_port), .smi_pulse(smi_pulse)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic route(input longint unsigned a, input int smm, input int wr,
                       output int tgt, output int drop, output string tag);
    longint unsigned sz;
    case (m_tsz)
      0: sz = 64'd1 << 20;
      1: sz = 64'd2 << 20;
      2: sz = 64'd8 << 20;
      default: sz = 0;
    endcase
    drop = 0;
    if (a >= FLASH) begin
      tgt = 3; drop = (wr != 0 && smm == 0) ? 1 : 0; tag = "R6";
    end else if (a >= 64'hA0000 && a < 64'hC0000) begin
      if (m_en != 0 && (smm != 0 || m_open != 0)) begin tgt = 0; tag = "R3"; end
      else begin tgt = 1; tag = "R2"; end
    end else if (sz != 0 && a >= TOLUD - sz && a < TOLUD) begin
      if (smm != 0) begin tgt = 0; tag = "R4"; end
      else begin tgt = 2; drop = wr; tag = "R5"; end
    end else if (a < TOLUD) begin
      tgt = 0; tag = "R11";
    end else begin
      tgt = 2; drop = wr; tag = "R11";
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_en = 0; m_open = 0; m_tsz = 3; m_lock = 0;
      e_valid = 0; e_smi = 0; e_tgt = 0; e_drop = 0; e_tag = "R1";
    end else begin
      int t, d;
      string g;
      route(req_addr, req_smm, req_write, t, d, g);
      e_valid = req_valid;
      e_tgt = t; e_drop = d; e_tag = g;
      e_smi = (io_valid && io_write && io_port == 16'h00B2) ? 1 : 0;
      if (cfg_we && m_lock == 0) begin
        m_en = cfg_wdata[0]; m_open = cfg_wdata[1];
        m_tsz = cfg_wdata[3:2]; m_lock = cfg_wdata[4];
        if (m_lock != 0) m_open = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      int ecfg;
      ecfg = (m_lock << 4) | (m_tsz << 2) | (m_open << 1) | m_en;
      chk(rsp_valid == e_valid[0], "R10", "rsp_valid", rsp_valid, e_valid);
      chk(smi_pulse == e_smi[0], "R9", "smi_pulse", smi_pulse, e_smi);
      chk(cfg_q == ecfg[4:0], "R7", "cfg_q", cfg_q, ecfg);
      if (e_valid != 0) begin
        chk(rsp_target == e_tgt[1:0], e_tag, "rsp_target", rsp_target, e_tgt);
        chk(rsp_drop == e_drop[0], e_tag, "rsp_drop", rsp_drop, e_drop);
      end
    end
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_write = 0; req_smm = 0;
    cfg_we = 0; io_valid = 0; io_write = 0;
  endtask

  task automatic mem(input longint unsigned a, input bit smm, input bit wr);
    @(negedge clk);
    cfg_we = 0; io_valid = 0; io_write = 0;
    req_valid = 1; req_addr = a[31:0]; req_smm = smm; req_write = wr;
  endtask

  task automatic cfg(input logic [4:0] d);
    @(negedge clk);
    req_valid = 0; io_valid = 0; io_write = 0;
    cfg_we = 1; cfg_wdata = d;
  endtask

  task automatic io(input logic [15:0] p, input bit wr);
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    io_valid = 1; io_write = wr; io_port = p;
  endtask

  task automatic probe_all();
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 2; w++) begin
        mem(64'hA0000, s[0], w[0]);
        mem(64'hBFFFF, s[0], w[0]);
        mem(64'hC0000, s[0], w[0]);
        mem(64'h9FFFF, s[0], w[0]);
        mem(TOLUD - (64'd1 << 20), s[0], w[0]);
        mem(TOLUD - (64'd1 << 20) - 1, s[0], w[0]);
        mem(TOLUD - (64'd2 << 20), s[0], w[0]);
        mem(TOLUD - (64'd8 << 20), s[0], w[0]);
        mem(TOLUD - (64'd8 << 20) - 1, s[0], w[0]);
        mem(TOLUD - 1, s[0], w[0]);
        mem(TOLUD, s[0], w[0]);
        mem(FLASH - 1, s[0], w[0]);
        mem(FLASH, s[0], w[0]);
        mem(64'hFFFF_FFF0, s[0], w[0]);
      end
    end
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    cmp_on = 1'b1;
    @(negedge clk);
    // R1: reset values at the ports
    chk(cfg_q == 5'b01100, "R1", "cfg_q reset", cfg_q, 5'b01100);
    chk(rsp_valid == 1'b0 && smi_pulse == 1'b0, "R1", "outputs reset",
        {rsp_valid, smi_pulse}, 0);
    rst = 1'b0;
    idle();
    probe_all();                 // R2, R6, R11 with enable off, no segment
    cfg(5'b00001); idle();       // enable, 1 MB segment: R3, R4, R5
    probe_all();
    cfg(5'b00011); idle();       // open
    probe_all();
    cfg(5'b00101); idle();       // 2 MB
    probe_all();
    cfg(5'b01001); idle();       // 8 MB
    probe_all();
    cfg(5'b01101); idle();       // segment off
    probe_all();
    // R8: lock together with open
    cfg(5'b10111); idle();
    chk(cfg_q[1] == 1'b0, "R8", "open under lock", cfg_q[1], 0);
    chk(cfg_q[4] == 1'b1, "R7", "lock set", cfg_q[4], 1);
    // R7: later writes ignored
    cfg(5'b01110); idle();
    cfg(5'b00000); idle();
    chk(cfg_q == 5'b10101, "R7", "frozen cfg", cfg_q, 5'b10101);
    probe_all();
    // R9: trigger port behaviour
    io(16'h00B2, 1'b1); idle();
    io(16'h00B2, 1'b0); idle();
    io(16'h00B3, 1'b1); idle();
    io(16'h00B2, 1'b1); io(16'h00B2, 1'b1); idle(); idle();
    // reset clears lock
    @(negedge clk); rst = 1'b1;
    idle(); idle();
    chk(cfg_q == 5'b01100, "R1", "cfg after second reset", cfg_q, 5'b01100);
    rst = 1'b0;
    cfg(5'b00001); idle();
    chk(cfg_q == 5'b00001, "R7", "writable after reset", cfg_q, 5'b00001);
    probe_all();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule